// File: doc/BRIEF.md
# Masked Channel Autocycle Sequencer

This block keeps a multichannel converter busy without any software involvement. The set of channels to visit comes from an enable mask. Conversions are spaced by an interval timer whose period is 1, 2, 4 or 8 times a base time. The base time is a parameter counted in clock cycles, and a prescaler inside the block divides it from the system clock. Each time the interval expires, the block issues a one-cycle start pulse with the index of the next enabled channel. It then waits for the converter's done signal before it will issue another start.

Software configures the block through two write strobes. One loads the channel mask. The other loads a 4-bit configuration word made of a command bit, an autocycle enable bit and a 2-bit interval code. Any write to either register restarts the timer, and the channel order then begins again from the lowest enabled channel. A separate single-cycle strobe reports writes to the limit and hysteresis registers, which are held elsewhere. Each such write freezes the timer for that one cycle.

Top module: `autocycle_sequencer`

## Requirements
- R1: Starts are issued only while the configuration word has bit 3 (command) at 0, bit 2 (autocycle enable) at 1, and the channel mask is nonzero. In every other case conv_start stays low.
- R2: The interval code in configuration bits [1:0] sets the spacing between consecutive starts. Code 00 gives BASE_CYCLES clock cycles, 01 gives 2×, 10 gives 4× and 11 gives 8× BASE_CYCLES.
- R3: After the write that enables sequencing, the first conv_start appears exactly one interval of clock edges after the write edge, and it selects the lowest enabled channel.
- R4: Each later start selects the next enabled channel above the previous one. After the highest enabled channel, the sequence wraps to the lowest enabled channel. A single enabled channel therefore repeats.
- R5: A write to the mask or to the configuration word restarts the interval count from zero, and the next start selects the lowest enabled channel.
- R6: A limit_wr strobe during sequencing holds the timer for one cycle, which delays the next start by exactly one clock cycle.
- R7: conv_start is high for a single cycle at a time. conv_ch carries the selected channel index during that cycle and holds it afterwards.
- R8: While a conversion is outstanding (started but conv_done not yet seen), an expiring interval issues no start and its slot is skipped. The next start comes at the first expiry after conv_done.
- R9: After reset, conv_start and conv_ch are 0, the mask is all zero and autocycle is disabled, so writing only the mask starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mask_wr | input | 1 | Load strobe for the channel enable mask |
| mask_wdata | input | NUM_CH | New channel enable mask, bit i enables channel i |
| cfg_wr | input | 1 | Load strobe for the configuration word |
| cfg_wdata | input | 4 | {command, autocycle enable, interval code[1:0]} |
| limit_wr | input | 1 | Single-cycle strobe marking a limit or hysteresis register write |
| conv_done | input | 1 | Converter reports the current conversion finished |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_ch | output | CH_W | Channel index for the current or most recent start |

## Verification
The assertions assume that conv_done arrives only while a conversion is outstanding, that limit_wr is a single-cycle strobe, and that BASE_CYCLES is at least 2, so that two expiries can never fall on adjacent cycles. The stimulus answers each start with one done pulse on the following cycle. The one exception is the outstanding-conversion test, where a single done pulse is given late on purpose. The stimulus changes inputs only on falling edges and never raises a strobe for more than one cycle.

// File: rtl/acs_pkg.sv
// Shared types for the autocycle sequencer.
// Assumes: the configuration word is exactly four bits wide.
package acs_pkg;
    typedef struct packed {
        logic       cmd;      // command mode select, must be 0 to sequence
        logic       auto_en;  // autocycle enable
        logic [1:0] ivl;      // interval code: multiple = 2**ivl
    } acs_cfg_t;

    localparam int CFG_W = $bits(acs_cfg_t);
    localparam logic [1:0] IVL_RESET = 2'b11;
endpackage

// File: rtl/acs_tick_div.sv
// Prescaler that divides the clock down to the base-time tick.
// Emits tick for one cycle when the count reaches BASE_CYCLES-1 while running.
// Assumes: clr has priority over run; BASE_CYCLES >= 2.
module acs_tick_div #(
    parameter int BASE_CYCLES = 100,
    localparam int CW = (BASE_CYCLES > 1) ? $clog2(BASE_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam logic [CW-1:0] LAST = CW'(BASE_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Base tick fires on the last count of a running period.
    assign tick = run && !clr && (cnt == LAST);

    // Count base cycles, clearing on restart and freezing when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end

    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt));
    a_r5_div_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/acs_interval_ctr.sv
// Counts base ticks and flags the end of each interval.
// Interval length in ticks is 1, 2, 4 or 8 according to the 2-bit code.
// Assumes: the code changes only together with clr.
module acs_interval_ctr (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       tick,
    input  logic [1:0] ivl,
    output logic       expire
);
    logic [2:0] icnt;
    logic [2:0] lim;

    // Decode the interval code into the last tick index of an interval.
    always_comb begin
        case (ivl)
            2'b00:   lim = 3'd0;
            2'b01:   lim = 3'd1;
            2'b10:   lim = 3'd3;
            default: lim = 3'd7;
        endcase
    end

    // The interval ends on the tick that reaches the last index.
    assign expire = tick && (icnt == lim);

    // Advance on each tick and wrap at the end of the interval.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            icnt <= '0;
        end else if (tick) begin
            icnt <= expire ? 3'd0 : icnt + 3'd1;
        end
    end

    a_r5_interval_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (icnt == 3'd0));
    a_r2_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(icnt));
endmodule

// File: rtl/acs_chan_pick.sv
// Chooses the channel for the next start from the enable mask.
// Without the fresh flag it takes the next enabled channel above last and
// wraps to the lowest. With the fresh flag it takes the lowest enabled channel.
// Assumes: valid is low only for an all-zero mask.
module acs_chan_pick #(
    parameter int NUM_CH = 8,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic [CH_W-1:0]   last,
    input  logic              fresh,
    output logic [CH_W-1:0]   pick,
    output logic              valid
);
    logic [CH_W-1:0] low_idx;
    logic [CH_W-1:0] up_idx;
    logic            low_ok;
    logic            up_ok;

    // Priority scans for the lowest enabled channel and the lowest one above last.
    always_comb begin
        low_idx = '0;
        low_ok  = 1'b0;
        up_idx  = '0;
        up_ok   = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask[i]) begin
                low_idx = CH_W'(i);
                low_ok  = 1'b1;
                if (i > int'(last)) begin
                    up_idx = CH_W'(i);
                    up_ok  = 1'b1;
                end
            end
        end
    end

    assign pick  = (!fresh && up_ok) ? up_idx : low_idx;
    assign valid = low_ok;
endmodule

// File: rtl/autocycle_sequencer.sv
// Top of the masked channel autocycle sequencer.
// Holds the mask and configuration registers, runs the interval timer and
// issues one start per expired interval when no conversion is outstanding.
// Assumes: conv_done only arrives while a conversion is outstanding;
// limit_wr is a single-cycle strobe; BASE_CYCLES >= 2.
module autocycle_sequencer
    import acs_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int BASE_CYCLES = 100,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr,
    input  logic [NUM_CH-1:0] mask_wdata,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              limit_wr,
    input  logic              conv_done,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_ch
);
    logic [NUM_CH-1:0] mask_q;
    acs_cfg_t          cfg_q;
    logic              busy_q;
    logic              fresh_q;
    logic [CH_W-1:0]   last_q;

    logic              active;
    logic              restart;
    logic              run;
    logic              tick;
    logic              expire;
    logic              fire;
    logic [CH_W-1:0]   pick_ch;
    logic              pick_ok;

    // Sequencing condition and the timer control derived from it.
    assign active  = cfg_q.auto_en && !cfg_q.cmd && (|mask_q);
    assign restart = !active || mask_wr || cfg_wr;
    assign run     = active && !mask_wr && !cfg_wr && !limit_wr;
    assign fire    = expire && !restart && !busy_q && pick_ok;

    acs_tick_div #(
        .BASE_CYCLES(BASE_CYCLES)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (restart),
        .run  (run),
        .tick (tick)
    );

    acs_interval_ctr u_ivl (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .tick  (tick),
        .ivl   (cfg_q.ivl),
        .expire(expire)
    );

    acs_chan_pick #(
        .NUM_CH(NUM_CH)
    ) u_pick (
        .mask (mask_q),
        .last (last_q),
        .fresh(fresh_q),
        .pick (pick_ch),
        .valid(pick_ok)
    );

    // Software-visible mask and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            cfg_q  <= '{cmd: 1'b0, auto_en: 1'b0, ivl: IVL_RESET};
        end else begin
            if (mask_wr) mask_q <= mask_wdata;
            if (cfg_wr)  cfg_q  <= acs_cfg_t'(cfg_wdata);
        end
    end

    // Start pulse, channel output and sequence position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start <= 1'b0;
            conv_ch    <= '0;
            last_q     <= '0;
            fresh_q    <= 1'b1;
        end else begin
            conv_start <= fire;
            if (fire) begin
                conv_ch <= pick_ch;
                last_q  <= pick_ch;
            end
            if (restart)   fresh_q <= 1'b1;
            else if (fire) fresh_q <= 1'b0;
        end
    end

    // Outstanding-conversion flag, set by a start and cleared by done.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_q <= 1'b0;
        else if (fire)      busy_q <= 1'b1;
        else if (conv_done) busy_q <= 1'b0;
    end

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> !conv_start);
    a_r1_idle_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !conv_start);
    a_r4_pick_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> mask_q[pick_ch]);
    a_r7_ch_held: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start |=> $stable(conv_ch) || conv_start);
endmodule

// File: tb/autocycle_sequencer_tb.sv
module autocycle_sequencer_tb;
    localparam int NCH  = 8;
    localparam int BASE = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           mask_wr = 1'b0;
    logic [NCH-1:0] mask_wdata = '0;
    logic           cfg_wr = 1'b0;
    logic [3:0]     cfg_wdata = '0;
    logic           limit_wr = 1'b0;
    logic           conv_done = 1'b0;
    logic           conv_start;
    logic [2:0]     conv_ch;

    int  nvec = 0;
    int  nfail = 0;
    int  cyc = 0;
    bit  auto_done = 1'b1;
    bit  finished = 1'b0;

    // {mask, interval code}
    localparam logic [9:0] VEC [5] = '{
        10'b10100110_00,
        10'b10000001_01,
        10'b00010000_10,
        10'b11111111_00,
        10'b01001000_11
    };

    autocycle_sequencer #(.NUM_CH(NCH), .BASE_CYCLES(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .limit_wr(limit_wr),
        .conv_done(conv_done), .conv_start(conv_start), .conv_ch(conv_ch)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Converter model: answer each start with done on the next edge.
    initial forever begin
        @(negedge clk);
        if (auto_done) conv_done = conv_start;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_mask(input logic [NCH-1:0] m);
        mask_wr = 1'b1; mask_wdata = m;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    task automatic wr_cfg(input logic [3:0] c);
        cfg_wr = 1'b1; cfg_wdata = c;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_start(input int max_cyc, output int t);
        t = -1;
        for (int n = 0; n < max_cyc; n++) begin
            @(negedge clk);
            if (conv_start) begin
                t = cyc;
                break;
            end
        end
    endtask

    task automatic count_starts(input int ncyc, output int cnt);
        cnt = 0;
        for (int n = 0; n < ncyc; n++) begin
            @(negedge clk);
            if (conv_start) cnt++;
        end
    endtask

    function automatic int exp_next(input logic [NCH-1:0] m, input int last, input bit fresh);
        if (!fresh)
            for (int i = last + 1; i < NCH; i++) if (m[i]) return i;
        for (int i = 0; i < NCH; i++) if (m[i]) return i;
        return -1;
    endfunction

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        int t, t0, tp, cnt, last, ival;
        logic [NCH-1:0] m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(conv_start == 1'b0, "R9 start after reset", int'(conv_start), 0);
        check(conv_ch == 3'd0, "R9 channel after reset", int'(conv_ch), 0);
        wr_mask(8'hFF);
        count_starts(60, cnt);
        check(cnt == 0, "R9 autocycle off by default", cnt, 0);

        // Vector table: R2 spacing, R3 first start, R4 order and wrap
        foreach (VEC[v]) begin
            wr_cfg(4'b0000);
            m = VEC[v][9:2];
            ival = BASE << VEC[v][1:0];
            wr_mask(m);
            wr_cfg({2'b01, VEC[v][1:0]});
            t0 = cyc; tp = t0; last = -1;
            for (int k = 0; k < 5; k++) begin
                wait_start(2 * ival + 4, t);
                last = exp_next(m, last, k == 0);
                if (k == 0) begin
                    check(t - tp == ival, "R3 first start delay", t - tp, ival);
                    check(int'(conv_ch) == last, "R3 lowest channel first", int'(conv_ch), last);
                end else begin
                    check(t - tp == ival, "R2 interval spacing", t - tp, ival);
                    check(int'(conv_ch) == last, "R4 channel order", int'(conv_ch), last);
                end
                tp = t;
            end
        end

        // R1: command bit set blocks sequencing
        wr_mask(8'hFF);
        wr_cfg(4'b1100);
        count_starts(80, cnt);
        check(cnt == 0, "R1 command bit set", cnt, 0);
        // R1: empty mask blocks sequencing
        wr_mask(8'h00);
        wr_cfg(4'b0100);
        count_starts(80, cnt);
        check(cnt == 0, "R1 empty mask", cnt, 0);
        // R5: mask write while enabled starts from a fresh count
        wr_mask(8'b0010_0100);
        t0 = cyc;
        wait_start(20, t);
        check(t - t0 == BASE, "R5 mask write restart delay", t - t0, BASE);
        check(conv_ch == 3'd2, "R5 mask write lowest channel", int'(conv_ch), 2);

        // R5: configuration rewrite mid-interval restarts count and order
        wr_mask(8'b1111_0000);
        wr_cfg(4'b0101);
        t0 = cyc;
        wait_start(30, t);
        check(t - t0 == 2 * BASE, "R5 first start", t - t0, 2 * BASE);
        repeat (3) @(negedge clk);
        wr_cfg(4'b0101);
        t0 = cyc;
        wait_start(30, t);
        check(t - t0 == 2 * BASE, "R5 config write restart delay", t - t0, 2 * BASE);
        check(conv_ch == 3'd4, "R5 config write lowest channel", int'(conv_ch), 4);

        // R6: limit write holds the timer one cycle
        wr_mask(8'b0000_0110);
        wr_cfg(4'b0110);
        t0 = cyc;
        repeat (4) @(negedge clk);
        limit_wr = 1'b1;
        @(negedge clk);
        limit_wr = 1'b0;
        wait_start(40, t);
        check(t - t0 == 4 * BASE + 1, "R6 hold delays start", t - t0, 4 * BASE + 1);

        // R7: pulse width and held channel
        @(negedge clk);
        check(conv_start == 1'b0, "R7 single-cycle pulse", int'(conv_start), 0);
        check(conv_ch == 3'd1, "R7 channel held", int'(conv_ch), 1);

        // R8: outstanding conversion skips a slot
        wr_cfg(4'b0000);
        repeat (3) @(negedge clk);
        auto_done = 1'b0;
        conv_done = 1'b0;
        wr_cfg(4'b0100);
        t0 = cyc;
        wait_start(10, t);
        check(t - t0 == BASE, "R8 first start", t - t0, BASE);
        count_starts(t0 + 2 * BASE + 1 - cyc, cnt);
        check(cnt == 0, "R8 slot skipped while busy", cnt, 0);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        wait_start(20, t);
        check(t - t0 == 3 * BASE, "R8 start after done", t - t0, 3 * BASE);
        check(conv_ch == 3'd2, "R8 channel after done", int'(conv_ch), 2);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        auto_done = 1'b1;

        // R4: single enabled channel repeats
        wr_mask(8'b1000_0000);
        wr_cfg(4'b0100);
        for (int k = 0; k < 3; k++) begin
            wait_start(20, t);
            check(conv_ch == 3'd7, "R4 single channel repeats", int'(conv_ch), 7);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule